// File: doc/BRIEF.md
# Processor Channel Supervisor

This block supervises one processor channel from an independent reference clock. It combines three monitors. A windowed watchdog expects a service strobe from software once per period. The strobe must arrive neither too soon nor too late. An activity monitor expects a software-driven bit to keep changing level. A clock-loss detector watches the processor clock for edges.

A watchdog fault of either kind asks for a processor reset. This is a pulse of fixed length that sends the processor back to its start location. A stalled activity bit does not reset the processor. Instead it latches an output-depower signal, which only a full reset of the block clears. A lost processor clock produces no reset while the clock stays absent. The reset pulse is issued only once the clock returns.

All windows and timeouts are counted in reference-clock cycles. The service strobe is a one-cycle pulse synchronous to the reference clock. The activity bit and the processor clock are asynchronous and are synchronized inside the block. No data stream crosses the block's edge, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `chan_supervisor`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `reset_req` and `depower` are both 0.
- R2: The watchdog count starts at 0 on the first cycle after a block reset, after an accepted strobe, and after a reset pulse ends. It advances by one per cycle. A strobe sampled while the count is between WIN_OPEN and WIN_CLOSE inclusive is accepted: no reset follows, and the count restarts.
- R3: A strobe sampled while the count is below WIN_OPEN is an early fault. `reset_req` is 1 from the clock edge that samples the strobe.
- R4: If no strobe has arrived when the count reaches WIN_CLOSE, `reset_req` rises at that edge. This is the (WIN_CLOSE+1)-th cycle after the count restarted.
- R5: `reset_req` stays high for exactly RST_PULSE cycles. While it is high, the watchdog is held at 0 and strobes are ignored. The count restarts when the pulse ends.
- R6: If the activity bit changes level more often than once per ACT_TIMEOUT cycles, `depower` stays 0. If it holds its level for ACT_TIMEOUT cycles plus the synchronizer latency (up to 4 cycles), `depower` becomes 1.
- R7: Once set, `depower` stays 1 until `rst_n` is asserted, even if the activity bit resumes toggling. It never causes `reset_req`.
- R8: If the synchronized processor clock shows no edge for CLK_LOSS_CYC reference cycles, the clock is declared lost. While it stays lost, `reset_req` remains 0 and the watchdog is held.
- R9: The first processor-clock edge after a loss starts a RST_PULSE-cycle reset pulse within 6 reference cycles.
- R10: A processor clock that is running is never declared lost, so accepted strobes never see a spurious reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Independent reference clock for all monitors |
| rst_n | input | 1 | Asynchronous active-low full reset |
| cpu_clk | input | 1 | Monitored processor clock (asynchronous) |
| svc_strobe | input | 1 | One-cycle service strobe, synchronous to ref_clk |
| act_bit | input | 1 | Software-toggled activity bit (asynchronous) |
| reset_req | output | 1 | Processor reset request pulse |
| depower | output | 1 | Latched output-depower request |

## Verification
Watchdog verdicts are due with no extra delay. `reset_req` reflects a strobe decision right after the edge that samples the strobe. The bench drives each strobe one negative edge before that sampling edge and reads the result at the next negative edge, so a strobe issued d cycles after a restart meets a count of exactly d.

The activity and clock monitors pass through a two-stage synchronizer. Their results are checked against windows rather than single cycles:
- `depower` must still be low at a point fewer than ACT_TIMEOUT cycles after the last toggle, and must be high a few cycles past it.
- After the processor clock restarts, the reset pulse must begin within six cycles.

Each pulse width is measured by counting consecutive negative edges on which `reset_req` is high.

// File: rtl/chan_sup_pkg.sv
package chan_sup_pkg;
  typedef enum logic [1:0] {
    WD_OK    = 2'd0,
    WD_EARLY = 2'd1,
    WD_LATE  = 2'd2
  } wd_verdict_t;
endpackage

// File: rtl/sig_edge_sync.sv
module sig_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic toggled
);
  logic [STAGES-1:0] chain;
  logic              last_lvl;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_lvl <= 1'b0;
    else        last_lvl <= chain[STAGES-1];
  end

  assign toggled = chain[STAGES-1] ^ last_lvl;
endmodule

// File: rtl/window_wdog.sv
module window_wdog
  import chan_sup_pkg::*;
#(
  parameter int WIN_OPEN  = 8,
  parameter int WIN_CLOSE = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hold,
  input  logic        strobe,
  output wd_verdict_t verdict
);
  localparam int CW = $clog2(WIN_CLOSE + 1);
  localparam logic [CW-1:0] OPEN_V  = CW'(WIN_OPEN);
  localparam logic [CW-1:0] CLOSE_V = CW'(WIN_CLOSE);

  logic [CW-1:0] cnt;
  logic          in_window;

  assign in_window = (cnt >= OPEN_V) && (cnt <= CLOSE_V);

  always_comb begin
    verdict = WD_OK;
    if (!hold) begin
      if (strobe) begin
        if (!in_window) verdict = WD_EARLY;
      end else if (cnt == CLOSE_V) begin
        verdict = WD_LATE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cnt <= '0;
    else if (hold || strobe || cnt == CLOSE_V) cnt <= '0;
    else                                    cnt <= cnt + 1'b1;
  end

  // R2: the count never runs past the closing edge of the window
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CLOSE_V);
endmodule

// File: rtl/activity_mon.sv
module activity_mon #(
  parameter int ACT_TIMEOUT = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_bit,
  output logic depower
);
  localparam int AW = $clog2(ACT_TIMEOUT + 1);
  localparam logic [AW-1:0] LIMIT_V = AW'(ACT_TIMEOUT);

  logic          act_edge;
  logic [AW-1:0] idle_cnt;

  sig_edge_sync #(.STAGES(SYNC_STAGES)) u_act_sync (
    .clk(clk), .rst_n(rst_n), .async_in(act_bit), .toggled(act_edge)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idle_cnt <= '0;
    else if (act_edge)          idle_cnt <= '0;
    else if (idle_cnt != LIMIT_V) idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       depower <= 1'b0;
    else if (!act_edge && idle_cnt == LIMIT_V - 1'b1) depower <= 1'b1;
  end

  // R6: idle count saturates at the timeout
  a_r6_idle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= LIMIT_V);
  // R7: depower is sticky until full reset
  a_r7_depower_latched: assert property (@(posedge clk) disable iff (!rst_n)
    depower |=> depower);
endmodule

// File: rtl/clk_loss_det.sv
module clk_loss_det #(
  parameter int CLK_LOSS_CYC = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_clk,
  output logic lost,
  output logic recovered
);
  localparam int LW = $clog2(CLK_LOSS_CYC + 1);
  localparam logic [LW-1:0] LOSS_V = LW'(CLK_LOSS_CYC);

  logic          mon_edge;
  logic [LW-1:0] quiet_cnt;

  sig_edge_sync #(.STAGES(SYNC_STAGES)) u_clk_sync (
    .clk(clk), .rst_n(rst_n), .async_in(mon_clk), .toggled(mon_edge)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  quiet_cnt <= '0;
    else if (mon_edge)           quiet_cnt <= '0;
    else if (quiet_cnt != LOSS_V) quiet_cnt <= quiet_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      lost <= 1'b0;
    else if (mon_edge)                               lost <= 1'b0;
    else if (quiet_cnt == LOSS_V - 1'b1)             lost <= 1'b1;
  end

  assign recovered = lost & mon_edge;

  // R8: a loss is only declared after a full quiet interval
  a_r8_loss_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> quiet_cnt == LOSS_V);
endmodule

// File: rtl/chan_supervisor.sv
module chan_supervisor
  import chan_sup_pkg::*;
#(
  parameter int WIN_OPEN     = 8,
  parameter int WIN_CLOSE    = 32,
  parameter int ACT_TIMEOUT  = 40,
  parameter int CLK_LOSS_CYC = 16,
  parameter int RST_PULSE    = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic cpu_clk,
  input  logic svc_strobe,
  input  logic act_bit,
  output logic reset_req,
  output logic depower
);
  localparam int PW = $clog2(RST_PULSE + 1);
  localparam logic [PW-1:0] PULSE_V = PW'(RST_PULSE);

  wd_verdict_t   verdict;
  logic          clk_lost;
  logic          clk_back;
  logic          trigger;
  logic [PW-1:0] pulse_cnt;
  logic          wd_hold;

  assign wd_hold = reset_req | clk_lost;

  window_wdog #(.WIN_OPEN(WIN_OPEN), .WIN_CLOSE(WIN_CLOSE)) u_wdog (
    .clk(ref_clk), .rst_n(rst_n), .hold(wd_hold),
    .strobe(svc_strobe), .verdict(verdict)
  );

  activity_mon #(.ACT_TIMEOUT(ACT_TIMEOUT), .SYNC_STAGES(SYNC_STAGES)) u_act (
    .clk(ref_clk), .rst_n(rst_n), .act_bit(act_bit), .depower(depower)
  );

  clk_loss_det #(.CLK_LOSS_CYC(CLK_LOSS_CYC), .SYNC_STAGES(SYNC_STAGES)) u_clkmon (
    .clk(ref_clk), .rst_n(rst_n), .mon_clk(cpu_clk),
    .lost(clk_lost), .recovered(clk_back)
  );

  assign trigger = (verdict != WD_OK) | clk_back;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)              pulse_cnt <= '0;
    else if (trigger)        pulse_cnt <= PULSE_V;
    else if (pulse_cnt != 0) pulse_cnt <= pulse_cnt - 1'b1;
  end

  assign reset_req = (pulse_cnt != '0);

  // R5: a reset pulse never collapses to a single cycle
  a_r5_pulse_hold: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(reset_req) |=> reset_req);
  // R8: no new reset while the processor clock remains lost
  a_r8_lost_quiet: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (clk_lost && $past(clk_lost)) |-> !$rose(reset_req));
  // R3/R4: the watchdog gives no verdict while held
  a_r3_held_silent: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $past(reset_req) && reset_req |-> verdict == WD_OK);
endmodule

// File: tb/chan_supervisor_tb.sv
module chan_supervisor_tb;
  localparam int WIN_OPEN     = 8;
  localparam int WIN_CLOSE    = 32;
  localparam int ACT_TIMEOUT  = 40;
  localparam int CLK_LOSS_CYC = 16;
  localparam int RST_PULSE    = 4;

  logic ref_clk = 1'b0;
  logic cpu_clk = 1'b0;
  logic cpu_run = 1'b1;
  logic rst_n   = 1'b0;
  logic svc     = 1'b0;
  logic act     = 1'b0;
  logic act_run = 1'b1;
  logic reset_req, depower;
  int   checks = 0;
  int   errors = 0;
  int   act_div = 0;

  always #4 ref_clk = ~ref_clk;
  always #10 cpu_clk = cpu_run ? ~cpu_clk : cpu_clk;

  always @(negedge ref_clk) begin
    if (act_run) begin
      act_div <= (act_div == 7) ? 0 : act_div + 1;
      if (act_div == 7) act <= ~act;
    end
  end

  chan_supervisor #(
    .WIN_OPEN(WIN_OPEN), .WIN_CLOSE(WIN_CLOSE), .ACT_TIMEOUT(ACT_TIMEOUT),
    .CLK_LOSS_CYC(CLK_LOSS_CYC), .RST_PULSE(RST_PULSE), .SYNC_STAGES(2)
  ) u_dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .cpu_clk(cpu_clk),
    .svc_strobe(svc), .act_bit(act), .reset_req(reset_req), .depower(depower)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int exp_fault(input int gap);
    return (gap < WIN_OPEN || gap > WIN_CLOSE) ? 1 : 0;
  endfunction

  // Called at a restart point; the strobe meets a count of exactly gap.
  task automatic strobe_gap(input int gap);
    repeat (gap) @(negedge ref_clk);
    svc = 1'b1;
    @(negedge ref_clk);
    svc = 1'b0;
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (reset_req && w < 100) begin
      w++;
      @(negedge ref_clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge ref_clk);
    chk("R1 reset_req in reset", int'(reset_req), 0);
    chk("R1 depower in reset", int'(depower), 0);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog_timer
    repeat (200000) @(posedge ref_clk);
    errors++;
    $display("FAIL watchdog timer expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int w;
    int gap;
    int lat;
    void'($urandom(32'd4725));
    @(negedge ref_clk);
    do_reset();
    chk("R1 reset_req after release", int'(reset_req), 0);

    // R2 boundaries: first and last accepted counts
    strobe_gap(WIN_OPEN);
    chk("R2 strobe at WIN_OPEN", int'(reset_req), 0);
    strobe_gap(WIN_CLOSE);
    chk("R2 strobe at WIN_CLOSE", int'(reset_req), 0);

    // R3 early by one, with R5 strobe ignored during the pulse
    strobe_gap(WIN_OPEN - 1);
    chk("R3 early strobe", int'(reset_req), 1);
    svc = 1'b1;
    @(negedge ref_clk);
    svc = 1'b0;
    pulse_width(w);
    chk("R5 pulse width with strobe inside", w + 1, RST_PULSE);

    // R4 late: restart point exactly at pulse end (R5)
    repeat (WIN_CLOSE) @(negedge ref_clk);
    chk("R4 no reset before close", int'(reset_req), 0);
    @(negedge ref_clk);
    chk("R4 late reset", int'(reset_req), 1);
    pulse_width(w);
    chk("R5 pulse width late", w, RST_PULSE);

    // R3 strobe at count 0
    strobe_gap(0);
    chk("R3 strobe at zero", int'(reset_req), 1);
    pulse_width(w);
    chk("R5 pulse width early", w, RST_PULSE);

    // random gaps, R2/R3/R10
    for (int i = 0; i < 40; i++) begin
      gap = $urandom_range(WIN_CLOSE, 0);
      strobe_gap(gap);
      chk(exp_fault(gap) ? "R3 random early" : "R2 R10 random accepted",
          int'(reset_req), exp_fault(gap));
      if (reset_req) begin
        pulse_width(w);
        chk("R5 random pulse width", w, RST_PULSE);
      end
    end
    chk("R6 depower low while toggling", int'(depower), 0);

    // R6/R7 activity stall, strobes keep the watchdog happy
    act_run = 1'b0;
    strobe_gap(16);
    strobe_gap(16);
    chk("R6 depower still low before timeout", int'(depower), 0);
    strobe_gap(16);
    chk("R6 depower after stall", int'(depower), 1);
    chk("R7 no reset from depower", int'(reset_req), 0);
    act_run = 1'b1;
    strobe_gap(16);
    strobe_gap(16);
    chk("R7 depower latched", int'(depower), 1);
    chk("R7 reset_req stays low", int'(reset_req), 0);
    do_reset();
    chk("R7 depower cleared by reset", int'(depower), 0);

    // R8/R9 clock loss and return
    cpu_run = 1'b0;
    w = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge ref_clk);
      if (reset_req) w++;
    end
    chk("R8 no reset while clock lost", w, 0);
    cpu_run = 1'b1;
    lat = 0;
    while (!reset_req && lat < 20) begin
      lat++;
      @(negedge ref_clk);
    end
    chk("R9 reset after clock return", int'(lat <= 6), 1);
    pulse_width(w);
    chk("R9 recovery pulse width", w, RST_PULSE);
    strobe_gap(WIN_OPEN + 2);
    chk("R10 watchdog normal after recovery", int'(reset_req), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule